// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It gets the 48-bit destination address of each incoming frame with a one-cycle strobe. Two cycles later it returns a single accept or drop verdict with its own strobe. A frame is admitted on any of three grounds:

- The promiscuous switch is on.
- An enabled exact-match entry holds the same address.
- The address is multicast and the bin it hashes to is set in a 64-bin hash table, with hashing switched on.

The hash bin comes from the Ethernet CRC-32 of the six address bytes, and the block computes it itself.

Configuration goes through a simple 16-bit write port. The block also holds a maximum frame length setting and drives its value out, for the length checks further down the receive path. Within a 48-bit address, bits 47:40 hold the first byte on the wire (byte0) and bits 7:0 hold the last (byte5). An address is multicast when bit 0 of byte0 (address bit 40) is set.

Top module: `rxf_da_filter`

## Requirements
- R1: After reset, `dec_valid` is low and `max_frame_len` equals `MAXLEN_RST` (1518). Entry 0 holds all-ones and is enabled, so the broadcast address is accepted. A unicast address is dropped.
- R2: Each cycle with `da_valid` high produces exactly one cycle of `dec_valid` two clock edges later. `dec_valid` never rises without such a strobe, and `dec_accept` is low whenever `dec_valid` is low.
- R3: Exact-match entry k keeps its address in three words at offsets 8+3k, 9+3k and 10+3k. The first word holds byte1 in bits 15:8 and byte0 in bits 7:0. The second holds byte3:byte2 and the third holds byte5:byte4. An enabled entry accepts exactly its own address and no address that differs in any bit.
- R4: Offset 0 holds the per-entry enable nibbles; entry k uses bits 4k+3:4k. The entry is enabled only when its nibble is 4'h9. A disabled entry never matches, even when its stored address equals the destination. With no enabled entry, no promiscuous mode and a unicast address, the frame is dropped.
- R5: The hash bin is bits 28:23 of the CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7, a seed of all-ones, bytes in order byte0 first and each byte least significant bit first, with no final inversion. Bin bits 5:4 select the hash word at offset 2, 3, 4 or 5, and bin bits 3:0 select the bit within that word.
- R6: Offset 1 bit 1 is the hash enable. A hash hit admits a frame only when the hash enable is set and the address is multicast. A unicast address whose bin is set is dropped, and with the hash enable clear the table admits nothing.
- R7: With all four hash words at 0xFFFF and hashing enabled, every multicast address is accepted and unicast addresses are still dropped.
- R8: Offset 1 bit 0 is the promiscuous switch. While it is set, every address is accepted.
- R9: A write to offset 6 appears on `max_frame_len` one cycle later.
- R10: Strobes on consecutive cycles each receive their own verdict, in the order the addresses arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (5) | Configuration word offset |
| cfg_wdata | input | 16 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte0 in bits 47:40 |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | 1 = accept frame, 0 = drop |
| max_frame_len | output | MAXLEN_W (16) | Configured maximum frame length |

## Verification
The assertions check on every cycle the properties that hold for every frame:

- the fixed two-cycle latency, with no verdict appearing without a strobe and no accept appearing without a verdict;
- the forced accept while promiscuous mode is on;
- the forced drop of a unicast address when no entry is enabled;
- the forced drop when nothing but a disabled hash could match;
- the one-cycle path from a length write to its output.

Only the bench scenarios can show the rest. These cover the byte-swapped word layout of the exact-match entries, the exact 4'h9 enable code, and that the CRC-derived bin picks the right word and bit. They also show that neighbouring addresses and bins stay rejected, and that back-to-back verdicts keep their order.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int unsigned ADDR_BYTES = 6;
   localparam int unsigned HASH_WORDS = 4;
   localparam int unsigned HASH_WBITS = 16;
   localparam int unsigned HASH_BINS  = HASH_WORDS * HASH_WBITS;
   localparam int unsigned HASH_IDX_W = $clog2(HASH_BINS);
   localparam int unsigned ENT_BITS   = 48;

   localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
   localparam logic [3:0]  ENT_ON     = 4'h9;

   // configuration word offsets
   localparam int unsigned OFS_ENABLES = 0;
   localparam int unsigned OFS_MODE    = 1;
   localparam int unsigned OFS_HASH0   = 2;
   localparam int unsigned OFS_MAXLEN  = 6;
   localparam int unsigned OFS_ENTRY0  = 8;

   // mode word bit positions
   localparam int unsigned MODE_PROMISC = 0;
   localparam int unsigned MODE_HASHEN  = 1;

   // CRC-32 over the six address bytes, byte0 (bits 47:40) first,
   // each byte least significant bit first; returns bits 28:23.
   function automatic logic [HASH_IDX_W-1:0] hash_bin(input logic [47:0] addr);
      logic [31:0] c;
      logic        b;
      c = '1;
      for (int i = 0; i < int'(ADDR_BYTES); i++) begin
         for (int j = 0; j < 8; j++) begin
            b = addr[40 - 8*i + j];
            c = {c[30:0], 1'b0} ^ ((c[31] ^ b) ? CRC_POLY : 32'h0);
         end
      end
      return c[28:23];
   endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
   import rxf_pkg::*;
#(
   parameter int unsigned NUM_EXACT  = 4,
   parameter int unsigned CFG_AW     = 5,
   parameter int unsigned MAXLEN_W   = 16,
   parameter int unsigned MAXLEN_RST = 1518
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [CFG_AW-1:0]             cfg_addr,
   input  logic [15:0]                   cfg_wdata,
   output logic [15:0]                   ent_enables,
   output logic                          promisc,
   output logic                          hash_en,
   output logic [HASH_BINS-1:0]          hash_tbl,
   output logic [NUM_EXACT*ENT_BITS-1:0] ent_words,
   output logic [MAXLEN_W-1:0]           max_len
);

   localparam logic [CFG_AW-1:0] A_ENABLES = CFG_AW'(OFS_ENABLES);
   localparam logic [CFG_AW-1:0] A_MODE    = CFG_AW'(OFS_MODE);
   localparam logic [CFG_AW-1:0] A_MAXLEN  = CFG_AW'(OFS_MAXLEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_enables <= {12'h000, ENT_ON};
         promisc     <= 1'b0;
         hash_en     <= 1'b0;
         max_len     <= MAXLEN_W'(MAXLEN_RST);
      end else if (cfg_we) begin
         if (cfg_addr == A_ENABLES) ent_enables <= cfg_wdata;
         if (cfg_addr == A_MODE) begin
            promisc <= cfg_wdata[MODE_PROMISC];
            hash_en <= cfg_wdata[MODE_HASHEN];
         end
         if (cfg_addr == A_MAXLEN) max_len <= cfg_wdata[MAXLEN_W-1:0];
      end
   end

   for (genvar h = 0; h < int'(HASH_WORDS); h++) begin : g_hash
      logic [HASH_WBITS-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (cfg_we && cfg_addr == CFG_AW'(OFS_HASH0 + h))
            word_q <= cfg_wdata;
      end
      assign hash_tbl[h*HASH_WBITS +: HASH_WBITS] = word_q;
   end

   for (genvar k = 0; k < int'(NUM_EXACT); k++) begin : g_ent
      for (genvar w = 0; w < 3; w++) begin : g_word
         localparam logic [15:0] WRST = (k == 0) ? 16'hFFFF : 16'h0000;
         logic [15:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= WRST;
            else if (cfg_we && cfg_addr == CFG_AW'(OFS_ENTRY0 + 3*k + w))
               word_q <= cfg_wdata;
         end
         assign ent_words[k*ENT_BITS + 16*w +: 16] = word_q;
      end
   end

   // R9
   maxlen_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == A_MAXLEN) |=> (max_len == $past(cfg_wdata[MAXLEN_W-1:0])));

endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match
   import rxf_pkg::*;
#(
   parameter int unsigned NUM_EXACT = 4
) (
   input  logic [47:0]                   da,
   input  logic [15:0]                   ent_enables,
   input  logic [NUM_EXACT*ENT_BITS-1:0] ent_words,
   output logic [NUM_EXACT-1:0]          hit_vec,
   output logic                          hit_any
);

   for (genvar k = 0; k < int'(NUM_EXACT); k++) begin : g_cmp
      logic [15:0] w0, w1, w2;
      logic [47:0] stored;
      logic        on;
      assign w0 = ent_words[k*ENT_BITS      +: 16];
      assign w1 = ent_words[k*ENT_BITS + 16 +: 16];
      assign w2 = ent_words[k*ENT_BITS + 32 +: 16];
      // each word keeps the lower-numbered byte in its low half
      assign stored = {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]};
      assign on     = (ent_enables[4*k +: 4] == ENT_ON);
      assign hit_vec[k] = on && (stored == da);
   end

   assign hit_any = |hit_vec;

endmodule

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup
   import rxf_pkg::*;
(
   input  logic [47:0]           da,
   input  logic [HASH_BINS-1:0]  hash_tbl,
   output logic [HASH_IDX_W-1:0] bin,
   output logic                  bin_set
);

   logic [1:0] word_sel;
   logic [3:0] bit_sel;

   assign bin      = hash_bin(da);
   assign word_sel = bin[5:4];
   assign bit_sel  = bin[3:0];
   assign bin_set  = hash_tbl[{word_sel, bit_sel}];

endmodule

// File: rtl/rxf_da_filter.sv
module rxf_da_filter
   import rxf_pkg::*;
#(
   parameter int unsigned NUM_EXACT  = 4,
   parameter int unsigned CFG_AW     = 5,
   parameter int unsigned MAXLEN_W   = 16,
   parameter int unsigned MAXLEN_RST = 1518
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_AW-1:0]   cfg_addr,
   input  logic [15:0]         cfg_wdata,
   input  logic                da_valid,
   input  logic [47:0]         da,
   output logic                dec_valid,
   output logic                dec_accept,
   output logic [MAXLEN_W-1:0] max_frame_len
);

   localparam int unsigned MAP_END = OFS_ENTRY0 + 3*NUM_EXACT;

   if (NUM_EXACT < 1 || NUM_EXACT > 4) begin : g_bad_exact
      $error("NUM_EXACT must be 1..4");
   end
   if ((1 << CFG_AW) < MAP_END) begin : g_bad_aw
      $error("CFG_AW too narrow for the register map");
   end
   if (MAXLEN_W < 1 || MAXLEN_W > 16) begin : g_bad_len
      $error("MAXLEN_W must be 1..16");
   end

   logic [15:0]                   ent_enables;
   logic                          promisc, hash_en;
   logic [HASH_BINS-1:0]          hash_tbl;
   logic [NUM_EXACT*ENT_BITS-1:0] ent_words;
   logic [NUM_EXACT-1:0]          hit_vec;
   logic                          hit_any;
   logic [HASH_IDX_W-1:0]         bin;
   logic                          bin_set;
   logic                          is_mcast;

   rxf_cfg_regs #(
      .NUM_EXACT (NUM_EXACT),
      .CFG_AW    (CFG_AW),
      .MAXLEN_W  (MAXLEN_W),
      .MAXLEN_RST(MAXLEN_RST)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .ent_enables(ent_enables),
      .promisc    (promisc),
      .hash_en    (hash_en),
      .hash_tbl   (hash_tbl),
      .ent_words  (ent_words),
      .max_len    (max_frame_len)
   );

   rxf_exact_match #(.NUM_EXACT(NUM_EXACT)) u_exact (
      .da         (da),
      .ent_enables(ent_enables),
      .ent_words  (ent_words),
      .hit_vec    (hit_vec),
      .hit_any    (hit_any)
   );

   rxf_hash_lookup u_hash (
      .da      (da),
      .hash_tbl(hash_tbl),
      .bin     (bin),
      .bin_set (bin_set)
   );

   assign is_mcast = da[40];

   // stage 1: per-source verdicts
   logic s1_valid, s1_promisc, s1_exact, s1_hash_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid   <= 1'b0;
         s1_promisc <= 1'b0;
         s1_exact   <= 1'b0;
         s1_hash_ok <= 1'b0;
      end else begin
         s1_valid   <= da_valid;
         s1_promisc <= promisc;
         s1_exact   <= hit_any;
         s1_hash_ok <= hash_en && is_mcast && bin_set;
      end
   end

   // stage 2: combined verdict
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= s1_valid;
         dec_accept <= s1_valid && (s1_promisc || s1_exact || s1_hash_ok);
      end
   end

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |-> ##2 dec_valid);
   // R2
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |-> ##2 !dec_valid);
   // R2
   accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_accept);
   // R8
   promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && promisc) |-> ##2 dec_accept);
   // R4
   no_entry_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !promisc && !is_mcast && !hit_any) |-> ##2 !dec_accept);
   // R6
   hash_off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !promisc && !hash_en && !hit_any) |-> ##2 !dec_accept);

endmodule

// File: tb/rxf_da_filter_bench.sv
`timescale 1ns/1ps
module rxf_da_filter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        da_valid = 1'b0;
   logic [47:0] da = '0;
   logic        dec_valid, dec_accept;
   logic [15:0] max_frame_len;

   always #2.5 clk = ~clk;

   rxf_da_filter u_rxf_da_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
      .dec_valid(dec_valid), .dec_accept(dec_accept),
      .max_frame_len(max_frame_len)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // shadow configuration
   logic [15:0] sh_en = 16'h0009;
   bit          sh_prom = 0, sh_hen = 0;
   logic [15:0] sh_hash [4] = '{default: 16'h0};
   logic [15:0] sh_ent [4][3];

   typedef struct {
      bit          exp;
      logic [47:0] addr;
      int          cyc_in;
      string       rq;
   } item_t;
   item_t sb[$];

   function automatic logic [5:0] ref_bin(input logic [47:0] a);
      logic [31:0] r = 32'hFFFF_FFFF;
      logic [7:0]  by;
      for (int i = 0; i < 6; i++) begin
         by = a[47 - 8*i -: 8];
         for (int j = 0; j < 8; j++) begin
            if (r[31] != by[j]) r = (r << 1) ^ 32'h04C11DB7;
            else                r = r << 1;
         end
      end
      return r[28:23];
   endfunction

   function automatic bit model(input logic [47:0] a);
      bit hit = 0;
      logic [5:0] b;
      for (int k = 0; k < 4; k++) begin
         logic [47:0] s;
         s = {sh_ent[k][0][7:0], sh_ent[k][0][15:8], sh_ent[k][1][7:0],
              sh_ent[k][1][15:8], sh_ent[k][2][7:0], sh_ent[k][2][15:8]};
         if (sh_en[4*k +: 4] == 4'h9 && s == a) hit = 1;
      end
      b = ref_bin(a);
      if (sh_hen && a[40] && sh_hash[b[5:4]][b[3:0]]) hit = 1;
      return sh_prom || hit;
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic wr(input int ofs, input logic [15:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 5'(ofs); cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (ofs == 0) sh_en = v;
      else if (ofs == 1) begin sh_prom = v[0]; sh_hen = v[1]; end
      else if (ofs >= 2 && ofs <= 5) sh_hash[ofs-2] = v;
      else if (ofs >= 8 && ofs < 20) sh_ent[(ofs-8)/3][(ofs-8)%3] = v;
   endtask

   task automatic load_entry(input int k, input logic [47:0] a);
      wr(8 + 3*k,     {a[39:32], a[47:40]});
      wr(8 + 3*k + 1, {a[23:16], a[31:24]});
      wr(8 + 3*k + 2, {a[7:0],   a[15:8]});
   endtask

   // drives one strobe cycle; keeps da_valid high for back-to-back use
   task automatic push(input logic [47:0] a, input string rq);
      item_t it;
      @(negedge clk);
      da_valid = 1'b1; da = a;
      it.exp = model(a); it.addr = a; it.cyc_in = cyc; it.rq = rq;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      da_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_push(input logic [47:0] a, input bit want, input string rq);
      check(model(a) == want, rq, "scenario-intent", model(a), want);
      push(a, rq);
      idle(3);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk); #1;
         if (rst_n && dec_valid) begin
            if (sb.size() == 0) begin
               check(0, "R2", "verdict-without-strobe", 1, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(dec_accept == it.exp, it.rq, "accept", dec_accept, it.exp);
               check(cyc - it.cyc_in == 2, "R2", "latency", cyc - it.cyc_in, 2);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(200000 * 5.0);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [47:0] ua, ma, mb, uu;
      logic [5:0]  bn;
      for (int k = 0; k < 4; k++)
         for (int w = 0; w < 3; w++) sh_ent[k][w] = (k == 0) ? 16'hFFFF : 16'h0;

      repeat (4) @(negedge clk);
      // R1 reset state
      check(dec_valid == 0, "R1", "dec_valid in reset", dec_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(max_frame_len == 16'd1518, "R1", "max_frame_len", max_frame_len, 1518);
      expect_push(48'hFFFF_FFFF_FFFF, 1, "R1");
      expect_push(48'h0011_2233_4455, 0, "R1");

      // R3 exact match with byte-swapped words
      ua = 48'h0207_4300_1309;
      load_entry(1, ua);
      wr(0, 16'h0099);
      expect_push(ua, 1, "R3");
      expect_push(ua ^ 48'h1, 0, "R3");
      expect_push(ua ^ 48'h0100_0000_0000, 0, "R3");

      // R4 enable codes
      wr(0, 16'h0089);
      expect_push(ua, 0, "R4");
      wr(0, 16'h0090);
      expect_push(48'hFFFF_FFFF_FFFF, 0, "R4");
      expect_push(ua, 1, "R4");
      wr(0, 16'h0000);
      expect_push(ua, 0, "R4");

      // R5 hash bin selection
      ma = 48'h0100_5E00_0001;
      bn = ref_bin(ma);
      wr(1, 16'h0002);
      wr(2 + bn[5:4], 16'(1) << bn[3:0]);
      expect_push(ma, 1, "R5");
      mb = ma;
      for (int i = 0; i < 64; i++) begin
         if (ref_bin(mb) != bn) break;
         mb = mb + 1;
      end
      expect_push(mb, 0, "R5");

      // R6 hash enable and multicast qualifier
      wr(1, 16'h0000);
      expect_push(ma, 0, "R6");
      wr(1, 16'h0002);
      uu = 48'h0200_0000_0000;
      for (int i = 0; i < 256; i++) begin
         if (ref_bin(uu) == bn) break;
         uu = uu + 1;
      end
      expect_push(uu, 0, "R6");

      // R7 all-ones table
      for (int h = 0; h < 4; h++) wr(2 + h, 16'hFFFF);
      expect_push(48'h3333_0000_0001, 1, "R7");
      expect_push(48'h0100_5EAA_BBCC, 1, "R7");
      expect_push(48'h0A0B_0C0D_0E0F, 0, "R7");

      // R8 promiscuous
      wr(1, 16'h0001);
      expect_push(48'h0A0B_0C0D_0E0F, 1, "R8");
      expect_push(48'h0000_0000_0000, 1, "R8");
      wr(1, 16'h0000);
      expect_push(48'h0A0B_0C0D_0E0F, 0, "R8");

      // R9 max length register
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 5'd6; cfg_wdata = 16'd9018;
      @(negedge clk);
      cfg_we = 1'b0;
      check(max_frame_len == 16'd9018, "R9", "max_frame_len", max_frame_len, 9018);

      // R10 back-to-back strobes, mixed verdicts
      wr(0, 16'h0099);
      push(ua, "R10");
      push(48'hFFFF_FFFF_FFFF, "R10");
      push(48'h0A0B_0C0D_0E0F, "R10");
      push(ua ^ 48'h10, "R10");
      push(ua, "R10");
      push(48'h0000_0000_0001, "R10");
      idle(6);
      check(sb.size() == 0, "R10", "pending verdicts", sb.size(), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule